// File: doc/BRIEF.md
# UART Host Register and Interrupt Controller

This block is the processor side of a UART. A CPU talks to it over a simple 32-bit memory-mapped bus with single-cycle writes and a combinational read path. The block queues outgoing characters in a transmit FIFO and incoming characters in a receive FIFO, each 16 entries of 8 bits. It keeps six sticky event flags and raises a single interrupt line when any enabled flag is set. The line-side serializer, deserializer and baud generator are separate blocks. This block exports the frame configuration and the raw baud word to them and exchanges characters with them.

Software changes flags only through a write-only action word. That word has one bit to set and one bit to clear each flag, plus bits that pop the receive FIFO and flush either FIFO. Receive-ready is raised a programmable number of bit ticks after the first character lands in an empty receive FIFO, so that a burst can build up before the CPU is interrupted. Transmit-ready is raised whenever the transmit FIFO level is at or below a programmable threshold.

Top module: `uart_host_regs`

## Requirements
- R1: Register words are selected by `bus_addr[4:2]`: 0 data, 1 control, 2 baud, 3 action, 4 status, 5 identification. Control bits 25:0 and baud bits 15:0 read back as written, with the upper bits reading 0. The identification word reads the `ID_WORD` parameter. Writes to status and identification have no effect. After reset, control and baud are 0.
- R2: The control fields are exported continuously: bits 8:6 on `cfg_char_len`, bit 9 on `cfg_parity_en`, bit 10 on `cfg_parity_even`, bit 11 on `cfg_two_stop` and bit 12 on `cfg_handshake_en`. Baud bits 11:0 appear on `baud_mant` and bits 15:12 on `baud_exp`.
- R3: While control bit 13 is 1, `line_txd` is 0. Otherwise `line_txd` equals `ser_txd`.
- R4: A write to the data word pushes `bus_wdata[7:0]` into the transmit FIFO if it holds fewer than 16 characters; otherwise the write is dropped. `tx_valid` is 1 when the FIFO is not empty, and `tx_data` shows the oldest character. A character leaves the FIFO on each clock edge at which `tx_valid` and `tx_ready` are both 1.
- R5: An `rx_valid` pulse stores `rx_data` in the receive FIFO. Action bit 10 moves the oldest character into the data read register, which reads it back in bits 7:0. A pop on an empty FIFO leaves the data read register unchanged.
- R6: A character that arrives while the receive FIFO holds 16 characters is dropped, and the overrun flag is set.
- R7: Action bit 11 empties the receive FIFO and action bit 12 empties the transmit FIFO.
- R8: Status bit 0 is receive-ready, bit 1 transmit-ready, bit 2 overrun, bit 3 break, bit 4 framing error and bit 5 parity error. Bits 10:6 hold the receive FIFO count and bits 15:11 the transmit FIFO count.
- R9: Action bits 0 to 4 clear, and bits 5 to 9 set, the receive-ready, overrun, break, framing and parity flags in that order. Bit 13 clears and bit 14 sets transmit-ready. When a flag's set and clear bits are written together, the flag ends up set.
- R10: Control bits 21:14 hold a delay D. When a character enters an empty receive FIFO, receive-ready is set at the same edge if D is 0. Otherwise it is set at the edge of the D-th following `bit_tick`. Flushing the receive FIFO cancels a pending delay.
- R11: Control bits 25:22 hold a threshold T. Transmit-ready is set at each clock edge at which the transmit FIFO count, as it stood before that edge, is at most T.
- R12: `rx_valid` with `rx_frame_err` sets the framing flag, `rx_valid` with `rx_parity_err` sets the parity flag, and an `rx_break` pulse sets the break flag.
- R13: `irq` is 1 exactly when some flag is set while its enable is set. The enables are control bits 0 to 5, ordered receive-ready, overrun, break, framing, parity and transmit-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_data | input | 8 | Received character |
| rx_frame_err | input | 1 | Framing error, qualified by `rx_valid` |
| rx_parity_err | input | 1 | Parity error, qualified by `rx_valid` |
| rx_break | input | 1 | Break detected, one-cycle strobe |
| bit_tick | input | 1 | One pulse per bit time |
| tx_valid | output | 1 | Transmit character available |
| tx_data | output | 8 | Oldest transmit character |
| tx_ready | input | 1 | Serializer accepts `tx_data` |
| ser_txd | input | 1 | Serial output from the serializer |
| line_txd | output | 1 | Serial line output, gated by forced break |
| cfg_char_len | output | 3 | Character length code |
| cfg_parity_en | output | 1 | Parity enabled |
| cfg_parity_even | output | 1 | Even parity selected |
| cfg_two_stop | output | 1 | Stop-bit count select |
| cfg_handshake_en | output | 1 | Hardware handshake enabled |
| cfg_force_break | output | 1 | Forced break active |
| baud_mant | output | 12 | Baud mantissa |
| baud_exp | output | 4 | Baud exponent |

## Verification
The transmit path is filled with 18 distinct bytes and then drained. This separates correct ordering and saturation at 16 from off-by-one pointer wrap and from accepting writes while full. Every transmit threshold from 0 to 15 is swept with a FIFO level of T+1 and then T, which pins down the at-or-below comparison at both sides of the boundary. The receive-ready delay is swept over several tick counts and checked after every tick, which separates counting ticks from counting cycles and catches an early or late fire. A full cross of the six enables against the six flags, together with a set, clear and both-at-once pattern on every flag, shows that each action bit and each enable reaches exactly one flag.

// File: rtl/uart_host_pkg.sv
// uart_host_pkg: word map, flag indices, control layout and action bit
// positions shared by the UART host register block and its checker.
package uart_host_pkg;

    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 8;
    localparam int BUS_W       = 32;
    localparam int BAUD_W      = 16;
    localparam int BAUD_MANT_W = 12;
    localparam int STAT_CNT_W  = 5;

    // Word index taken from bus_addr[4:2]
    typedef enum logic [2:0] {
        W_DATA   = 3'd0,
        W_CTRL   = 3'd1,
        W_BAUD   = 3'd2,
        W_ACTION = 3'd3,
        W_STATUS = 3'd4,
        W_IDENT  = 3'd5
    } word_e;

    // Flag indices; this order is also the enable and action order
    localparam int NFLAG    = 6;
    localparam int N_RXFLAG = 5;
    localparam int F_RRDY   = 0;
    localparam int F_OVR    = 1;
    localparam int F_BRK    = 2;
    localparam int F_FRM    = 3;
    localparam int F_PAR    = 4;
    localparam int F_TRDY   = 5;

    // Control word, bit 25 down to bit 0
    typedef struct packed {
        logic [3:0] tx_thr;
        logic [7:0] rdy_dly;
        logic       force_brk;
        logic       hs_en;
        logic       two_stop;
        logic       par_even;
        logic       par_en;
        logic [2:0] char_len;
        logic [5:0] irq_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Action word bit positions
    localparam int A_CLR_BASE = 0;
    localparam int A_SET_BASE = 5;
    localparam int A_RX_POP   = 10;
    localparam int A_RX_FLUSH = 11;
    localparam int A_TX_FLUSH = 12;
    localparam int A_TRDY_CLR = 13;
    localparam int A_TRDY_SET = 14;

    // Status flag byte: rrdy, trdy, ovr, brk, frm, par from bit 0 upward
    function automatic logic [5:0] status_flags(input logic [NFLAG-1:0] f);
        return {f[F_PAR], f[F_FRM], f[F_BRK], f[F_OVR], f[F_TRDY], f[F_RRDY]};
    endfunction

endpackage

// File: rtl/uart_host_fifo.sv
// uart_host_fifo: synchronous FIFO with flush and occupancy count.
// Assumes: push while full and pop while empty are ignored; flush wins
// over push and pop in the same cycle; dout shows the head combinationally.
module uart_host_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    // Advance a pointer with explicit wrap so any depth works
    function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Storage write; the array itself needs no reset
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= next_ptr(wr_ptr);
            if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uart_host_rdy_timer.sv
// uart_host_rdy_timer: counts bit ticks after a start and fires once the
// programmed delay is reached. Assumes: delay 0 fires in the start cycle;
// cancel overrides start; a delay lowered below the count fires on the next tick.
module uart_host_rdy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cancel,
    input  logic             tick,
    input  logic [CNT_W-1:0] delay,
    output logic             fire
);

    logic             pending;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_next;
    logic             reached;

    assign cnt_next = {1'b0, cnt} + (CNT_W + 1)'(1);
    assign reached  = pending && tick && (cnt_next >= {1'b0, delay});
    assign fire     = !cancel && ((start && delay == '0) || reached);

    // Track an armed delay and the ticks counted so far
    always_ff @(posedge clk) begin
        if (!rst_n || cancel) begin
            pending <= 1'b0;
            cnt     <= '0;
        end else if (start && delay != '0) begin
            pending <= 1'b1;
            cnt     <= '0;
        end else if (reached) begin
            pending <= 1'b0;
            cnt     <= '0;
        end else if (pending && tick) begin
            cnt     <= cnt_next[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/uart_host_flags.sv
// uart_host_flags: bank of sticky flags with per-flag set and clear and
// an enable-masked interrupt. Assumes: set beats clear for the same flag.
module uart_host_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] en_vec,
    output logic [N-1:0] flags,
    output logic         irq
);

    // One sticky bit per flag, set taking priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                flags[i] <= set_vec[i] | (flags[i] & ~clr_vec[i]);
            end
        end
    end

    // Interrupt request from any enabled flag
    assign irq = |(flags & en_vec);

endmodule

// File: rtl/uart_host_regs.sv
// uart_host_regs: CPU-facing register block of a UART with receive and
// transmit FIFOs, sticky flags and interrupt. Assumes: one-cycle write
// strobes, combinational reads without side effects, and line-side strobes
// one cycle wide.
module uart_host_regs
    import uart_host_pkg::*;
#(
    parameter int          FIFO_DEPTH = 16,
    parameter logic [31:0] ID_WORD    = 32'h5A17_0100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [BUS_W-1:0]       bus_wdata,
    output logic [BUS_W-1:0]       bus_rdata,
    output logic                   irq,
    input  logic                   rx_valid,
    input  logic [DATA_W-1:0]      rx_data,
    input  logic                   rx_frame_err,
    input  logic                   rx_parity_err,
    input  logic                   rx_break,
    input  logic                   bit_tick,
    output logic                   tx_valid,
    output logic [DATA_W-1:0]      tx_data,
    input  logic                   tx_ready,
    input  logic                   ser_txd,
    output logic                   line_txd,
    output logic [2:0]             cfg_char_len,
    output logic                   cfg_parity_en,
    output logic                   cfg_parity_even,
    output logic                   cfg_two_stop,
    output logic                   cfg_handshake_en,
    output logic                   cfg_force_break,
    output logic [BAUD_MANT_W-1:0] baud_mant,
    output logic [BAUD_W-BAUD_MANT_W-1:0] baud_exp
);

    localparam int CW = $clog2(FIFO_DEPTH + 1);

    // Register state
    ctrl_t             ctrl_q;
    logic [BAUD_W-1:0] baud_q;
    logic [DATA_W-1:0] rd_hold;

    // Decoded write strobes
    word_e      wsel;
    logic       wr_data;
    logic       wr_ctrl;
    logic       wr_baud;
    logic       wr_act;
    logic [BUS_W-1:0] act;

    // Action strobes
    logic act_rx_pop;
    logic act_rx_flush;
    logic act_tx_flush;

    // FIFO signals
    logic [DATA_W-1:0] rx_dout;
    logic [CW-1:0]     rx_cnt;
    logic              rx_full;
    logic              rx_empty;
    logic [CW-1:0]     tx_cnt;
    logic              tx_full;
    logic              tx_empty;

    // Flag bank signals
    logic [NFLAG-1:0]  set_vec;
    logic [NFLAG-1:0]  clr_vec;
    logic [NFLAG-1:0]  flags;
    logic              rrdy_fire;
    logic              rx_start;
    logic              rx_overrun;
    logic              tx_low;

    assign wsel    = word_e'(bus_addr[4:2]);
    assign wr_data = bus_wr && (wsel == W_DATA);
    assign wr_ctrl = bus_wr && (wsel == W_CTRL);
    assign wr_baud = bus_wr && (wsel == W_BAUD);
    assign wr_act  = bus_wr && (wsel == W_ACTION);
    assign act     = wr_act ? bus_wdata : '0;

    assign act_rx_pop   = act[A_RX_POP];
    assign act_rx_flush = act[A_RX_FLUSH];
    assign act_tx_flush = act[A_TX_FLUSH];

    // Configuration registers: control and raw baud word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            baud_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_baud) baud_q <= bus_wdata[BAUD_W-1:0];
        end
    end

    // Receive queue fed by the deserializer
    uart_host_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (act_rx_flush),
        .push  (rx_valid),
        .pop   (act_rx_pop),
        .din   (rx_data),
        .dout  (rx_dout),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    // Transmit queue fed by data-word writes
    uart_host_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (act_tx_flush),
        .push  (wr_data),
        .pop   (tx_ready),
        .din   (bus_wdata[DATA_W-1:0]),
        .dout  (tx_data),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    assign tx_valid = !tx_empty;

    // Data read register, loaded by a pop action on a non-empty queue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hold <= '0;
        end else if (act_rx_pop && !rx_empty && !act_rx_flush) begin
            rd_hold <= rx_dout;
        end
    end

    // Receive-ready hold-off after the first character of a burst
    assign rx_start = rx_valid && rx_empty && !act_rx_flush;

    uart_host_rdy_timer #(
        .CNT_W ($bits(ctrl_q.rdy_dly))
    ) u_rdy_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (rx_start),
        .cancel (act_rx_flush),
        .tick   (bit_tick),
        .delay  (ctrl_q.rdy_dly),
        .fire   (rrdy_fire)
    );

    assign rx_overrun = rx_valid && rx_full;
    assign tx_low     = (tx_cnt <= CW'(ctrl_q.tx_thr));

    // Action bits for the receive-side flags map one to one
    for (genvar i = 0; i < N_RXFLAG; i++) begin : g_rx_act
        assign clr_vec[i] = act[A_CLR_BASE + i];
    end
    assign clr_vec[F_TRDY] = act[A_TRDY_CLR];

    assign set_vec[F_RRDY] = act[A_SET_BASE + F_RRDY] | rrdy_fire;
    assign set_vec[F_OVR]  = act[A_SET_BASE + F_OVR]  | rx_overrun;
    assign set_vec[F_BRK]  = act[A_SET_BASE + F_BRK]  | rx_break;
    assign set_vec[F_FRM]  = act[A_SET_BASE + F_FRM]  | (rx_valid & rx_frame_err);
    assign set_vec[F_PAR]  = act[A_SET_BASE + F_PAR]  | (rx_valid & rx_parity_err);
    assign set_vec[F_TRDY] = act[A_TRDY_SET] | tx_low;

    uart_host_flags #(
        .N (NFLAG)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_vec  (ctrl_q.irq_en),
        .flags   (flags),
        .irq     (irq)
    );

    // Read multiplexer
    always_comb begin
        case (wsel)
            W_DATA:   bus_rdata = BUS_W'(rd_hold);
            W_CTRL:   bus_rdata = BUS_W'(ctrl_q);
            W_BAUD:   bus_rdata = BUS_W'(baud_q);
            W_STATUS: bus_rdata = {16'b0, STAT_CNT_W'(tx_cnt), STAT_CNT_W'(rx_cnt),
                                   status_flags(flags)};
            W_IDENT:  bus_rdata = ID_WORD;
            default:  bus_rdata = '0;
        endcase
    end

    // Line-side configuration exports
    assign cfg_char_len     = ctrl_q.char_len;
    assign cfg_parity_en    = ctrl_q.par_en;
    assign cfg_parity_even  = ctrl_q.par_even;
    assign cfg_two_stop     = ctrl_q.two_stop;
    assign cfg_handshake_en = ctrl_q.hs_en;
    assign cfg_force_break  = ctrl_q.force_brk;
    assign baud_mant        = baud_q[BAUD_MANT_W-1:0];
    assign baud_exp         = baud_q[BAUD_W-1:BAUD_MANT_W];
    assign line_txd         = ctrl_q.force_brk ? 1'b0 : ser_txd;

endmodule

// File: rtl/uart_host_regs_chk.sv
// uart_host_regs_chk: temporal properties of the UART host register block,
// attached to every instance of the top module by the bind below.
module uart_host_regs_chk
    import uart_host_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              rx_valid,
    input logic [CW-1:0]     rx_cnt,
    input logic [CW-1:0]     tx_cnt,
    input logic [NFLAG-1:0]  flags,
    input logic [3:0]        tx_thr,
    input logic [NFLAG-1:0]  irq_en,
    input logic              irq,
    input logic              force_brk,
    input logic              line_txd,
    input logic              act_rx_pop,
    input logic              act_rx_flush
);

    logic act_wr;
    assign act_wr = bus_wr && (bus_addr[4:2] == 3'd3);

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH)));

    // R6
    overrun_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_cnt == CW'(DEPTH) && !act_rx_pop && !act_rx_flush)
        |=> (rx_cnt == CW'(DEPTH)) && flags[F_OVR]);

    // R11
    tx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(tx_thr)) |=> flags[F_TRDY]);

    // R3
    force_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_brk |-> !line_txd);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_wr && bus_wdata[A_SET_BASE + F_BRK]) |=> flags[F_BRK]);

    // R7
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_wr && bus_wdata[A_TX_FLUSH]) |=> (tx_cnt == '0));

    // R13
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_wr && bus_wdata[A_SET_BASE + F_RRDY] && irq_en[F_RRDY]) |=> irq);

endmodule

bind uart_host_regs uart_host_regs_chk #(
    .DEPTH (FIFO_DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .rx_valid     (rx_valid),
    .rx_cnt       (rx_cnt),
    .tx_cnt       (tx_cnt),
    .flags        (flags),
    .tx_thr       (ctrl_q.tx_thr),
    .irq_en       (ctrl_q.irq_en),
    .irq          (irq),
    .force_brk    (cfg_force_break),
    .line_txd     (line_txd),
    .act_rx_pop   (act_rx_pop),
    .act_rx_flush (act_rx_flush)
);

// File: tb/tb_uart_host_regs.sv
// tb_uart_host_regs: self-checking sweeps over the UART host register block.
module tb_uart_host_regs;

    localparam logic [31:0] ID = 32'h5A17_0100;
    localparam logic [4:0] A_DATA = 5'd0, A_CTRL = 5'd4, A_BAUD = 5'd8,
                           A_ACT = 5'd12, A_STAT = 5'd16, A_ID = 5'd20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_frame_err = 1'b0;
    logic        rx_parity_err = 1'b0;
    logic        rx_break = 1'b0;
    logic        bit_tick = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        ser_txd = 1'b1;
    logic        line_txd;
    logic [2:0]  cfg_char_len;
    logic        cfg_parity_en, cfg_parity_even, cfg_two_stop;
    logic        cfg_handshake_en, cfg_force_break;
    logic [11:0] baud_mant;
    logic [3:0]  baud_exp;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_host_regs #(.FIFO_DEPTH(16), .ID_WORD(ID)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_err(rx_frame_err),
        .rx_parity_err(rx_parity_err), .rx_break(rx_break), .bit_tick(bit_tick),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .ser_txd(ser_txd), .line_txd(line_txd), .cfg_char_len(cfg_char_len),
        .cfg_parity_en(cfg_parity_en), .cfg_parity_even(cfg_parity_even),
        .cfg_two_stop(cfg_two_stop), .cfg_handshake_en(cfg_handshake_en),
        .cfg_force_break(cfg_force_break), .baud_mant(baud_mant), .baud_exp(baud_exp)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic rx_char(input logic [7:0] d, input logic fe, input logic pe);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_frame_err = fe; rx_parity_err = pe;
        @(negedge clk);
        rx_valid = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Status bit of each flag in action/enable order
    function automatic int sbit(input int f);
        return (f == 0) ? 0 : (f == 5) ? 1 : f + 1;
    endfunction

    function automatic logic [7:0] txv(input int n);
        return 8'((n * 37 + 5) & 255);
    endfunction

    function automatic logic [7:0] rxv(input int n);
        return 8'((n * 29 + 11) & 255);
    endfunction

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] cv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(A_CTRL, v); chk("R1 ctrl after reset", v, 32'h0);
        rd(A_BAUD, v); chk("R1 baud after reset", v, 32'h0);
        rd(A_ID, v);   chk("R1 ident word", v, ID);
        rd(A_STAT, v); chk("R8 R11 status after reset", v, 32'h2);
        chk("R13 irq after reset", {31'b0, irq}, 32'h0);
        chk("R4 tx_valid after reset", {31'b0, tx_valid}, 32'h0);
        chk("R3 line follows serializer", {31'b0, line_txd}, 32'h1);

        // Configuration exports and readback
        cv = (32'd5 << 6) | (32'd1 << 9) | (32'd1 << 11) | (32'd1 << 12) | 32'hFC00_0000;
        wr(A_CTRL, cv);
        rd(A_CTRL, v); chk("R1 ctrl readback", v, cv & 32'h03FF_FFFF);
        chk("R2 char len", {29'b0, cfg_char_len}, 32'd5);
        chk("R2 flags", {28'b0, cfg_parity_en, cfg_parity_even, cfg_two_stop, cfg_handshake_en},
            32'b1011);
        wr(A_BAUD, 32'hFFFF_ABCD);
        rd(A_BAUD, v); chk("R1 baud readback", v, 32'h0000_ABCD);
        chk("R2 baud mant", {20'b0, baud_mant}, 32'hBCD);
        chk("R2 baud exp", {28'b0, baud_exp}, 32'hA);
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_ID, 32'h0);
        rd(A_STAT, v); chk("R1 status write ignored", v, 32'h2);
        rd(A_ID, v);   chk("R1 ident write ignored", v, ID);
        wr(A_CTRL, 32'h0);

        // Forced break
        wr(A_CTRL, 32'h1 << 13);
        chk("R3 break with txd high", {31'b0, line_txd}, 32'h0);
        ser_txd = 1'b0; #1;
        chk("R3 break with txd low", {31'b0, line_txd}, 32'h0);
        wr(A_CTRL, 32'h0);
        chk("R3 release low", {31'b0, line_txd}, 32'h0);
        ser_txd = 1'b1; #1;
        chk("R3 release high", {31'b0, line_txd}, 32'h1);

        // Transmit fill past capacity, then drain in order
        for (int n = 0; n < 18; n++) begin
            wr(A_DATA, 32'hAB00 | 32'(txv(n)));
            rd(A_STAT, v);
            chk("R4 R8 tx count", 32'(v[15:11]), (n + 1 > 16) ? 32'd16 : 32'(n + 1));
        end
        @(negedge clk); tx_ready = 1'b1;
        for (int i = 0; i < 16; i++) begin
            #1;
            chk("R4 tx valid", {31'b0, tx_valid}, 32'h1);
            chk("R4 tx order", {24'b0, tx_data}, {24'b0, txv(i)});
            @(negedge clk);
        end
        tx_ready = 1'b0;
        chk("R4 tx drained", {31'b0, tx_valid}, 32'h0);

        // Transmit threshold sweep
        for (int t = 0; t < 16; t++) begin
            wr(A_CTRL, 32'(t) << 22);
            wr(A_ACT, 32'h1 << 12);
            for (int k = 0; k <= t; k++) wr(A_DATA, 32'(k));
            wr(A_ACT, 32'h1 << 13);
            rd(A_STAT, v); chk("R11 above threshold", 32'(v[1]), 32'h0);
            @(negedge clk); tx_ready = 1'b1;
            @(negedge clk); tx_ready = 1'b0;
            @(negedge clk);
            rd(A_STAT, v); chk("R11 at threshold", 32'(v[1]), 32'h1);
        end
        wr(A_ACT, 32'h1 << 12);
        rd(A_STAT, v); chk("R7 tx flush", 32'(v[15:11]), 32'h0);
        wr(A_CTRL, 32'h0);

        // Receive fill with overrun, then pop in order
        wr(A_ACT, (32'h1 << 11) | 32'h1F);
        for (int n = 0; n < 17; n++) begin
            rx_char(rxv(n), 1'b0, 1'b0);
            rd(A_STAT, v);
            chk("R5 R8 rx count", 32'(v[10:6]), (n + 1 > 16) ? 32'd16 : 32'(n + 1));
            chk("R6 overrun flag", 32'(v[2]), (n == 16) ? 32'h1 : 32'h0);
        end
        rd(A_STAT, v); chk("R10 zero delay ready", 32'(v[0]), 32'h1);
        for (int i = 0; i < 16; i++) begin
            wr(A_ACT, 32'h1 << 10);
            rd(A_DATA, v); chk("R5 rx order", v, 32'(rxv(i)));
            rd(A_STAT, v); chk("R5 rx count after pop", 32'(v[10:6]), 32'(15 - i));
        end
        wr(A_ACT, 32'h1 << 10);
        rd(A_DATA, v); chk("R5 pop on empty", v, 32'(rxv(15)));
        rx_char(8'h11, 1'b0, 1'b0);
        rx_char(8'h22, 1'b0, 1'b0);
        wr(A_ACT, 32'h1 << 11);
        rd(A_STAT, v); chk("R7 rx flush", 32'(v[10:6]), 32'h0);

        // Receive-ready delay sweep
        for (int d = 1; d <= 6; d++) begin
            wr(A_CTRL, 32'(d) << 14);
            wr(A_ACT, (32'h1 << 11) | 32'h1);
            rx_char(8'h5A, 1'b0, 1'b0);
            repeat (3) @(negedge clk);
            rd(A_STAT, v); chk("R10 held before ticks", 32'(v[0]), 32'h0);
            for (int k = 1; k <= d; k++) begin
                tick();
                rd(A_STAT, v);
                chk("R10 ready after tick", 32'(v[0]), (k >= d) ? 32'h1 : 32'h0);
            end
        end
        wr(A_CTRL, 32'd3 << 14);
        wr(A_ACT, (32'h1 << 11) | 32'h1);
        rx_char(8'h5A, 1'b0, 1'b0);
        wr(A_ACT, 32'h1 << 11);
        repeat (4) tick();
        rd(A_STAT, v); chk("R10 flush cancels delay", 32'(v[0]), 32'h0);
        wr(A_CTRL, 32'h0);

        // Set, clear and set-wins for every flag
        wr(A_ACT, 32'h1F);
        for (int f = 0; f < 5; f++) begin
            wr(A_ACT, 32'h1 << (5 + f));
            rd(A_STAT, v); chk("R9 set", 32'(v[sbit(f)]), 32'h1);
            wr(A_ACT, 32'h1 << f);
            rd(A_STAT, v); chk("R9 clear", 32'(v[sbit(f)]), 32'h0);
            wr(A_ACT, (32'h1 << f) | (32'h1 << (5 + f)));
            rd(A_STAT, v); chk("R9 set wins", 32'(v[sbit(f)]), 32'h1);
            wr(A_ACT, 32'h1 << f);
        end
        wr(A_DATA, 32'h77);
        wr(A_ACT, 32'h1 << 13);
        rd(A_STAT, v); chk("R9 trdy clear", 32'(v[1]), 32'h0);
        wr(A_ACT, (32'h1 << 13) | (32'h1 << 14));
        rd(A_STAT, v); chk("R9 trdy set wins", 32'(v[1]), 32'h1);

        // Line-side error strobes
        wr(A_ACT, 32'h1F | (32'h1 << 13));
        rx_char(8'h01, 1'b1, 1'b0);
        rd(A_STAT, v); chk("R12 framing", 32'(v[5:2]), 32'b0100);
        rx_char(8'h02, 1'b0, 1'b1);
        rd(A_STAT, v); chk("R12 parity", 32'(v[5:2]), 32'b1100);
        @(negedge clk); rx_break = 1'b1;
        @(negedge clk); rx_break = 1'b0;
        rd(A_STAT, v); chk("R12 break", 32'(v[5:2]), 32'b1110);
        wr(A_ACT, (32'h1 << 11) | 32'h1F);

        // Enable by flag cross for the interrupt
        for (int e = 0; e < 6; e++) begin
            wr(A_CTRL, 32'h1 << e);
            for (int f = 0; f < 6; f++) begin
                wr(A_ACT, (f < 5) ? (32'h1 << (5 + f)) : (32'h1 << 14));
                chk("R13 irq cross", {31'b0, irq}, (e == f) ? 32'h1 : 32'h0);
                wr(A_ACT, (f < 5) ? (32'h1 << f) : (32'h1 << 13));
                chk("R13 irq cleared", {31'b0, irq}, 32'h0);
            end
        end

        finish_run();
    end

endmodule